// File: doc/BRIEF.md
# Two-Pass RAM Integrity Tester

This block is a self-test engine for a synchronous single-port RAM with one cycle of read latency. A one-cycle `start` pulse launches a fixed sequence across every address of the RAM. First, each word is loaded with a value taken from its own address, and a read sweep checks the whole range. Next, each word is read and then written back as the bitwise inverse of what it returned. A last read sweep checks the inverted values. Across the two sweeps each bit cell has to hold a 0 and also a 1.

The engine drives the RAM's address, write data and write enable, and it takes the RAM's read data. When the run ends it raises `done` and gives one verdict: `pass` for a clean run, or `fail_irq` for a run that stopped at a mismatch. No mask or enable gates `fail_irq`. Both results hold until the next start or a reset. The engine stops at the first mismatch it sees, so a faulty RAM ends its run early.

Top module: `ram_selftest`

## Requirements
- R1: While reset is asserted and directly after it, `done`, `pass`, `fail_irq` and `ram_we` are all 0.
- R2: After the start edge, the engine writes to addresses 0, 1, ..., N-1 in ascending order, one per cycle (N = 2^ADDR_W). The data for address a is a taken modulo 2^DATA_W and zero-extended to DATA_W bits.
- R3: The first read sweep presents addresses 0 to N-1 one per cycle. It compares the read data of the following cycle with that address's fill value.
- R4: The inversion pass spends two cycles per address in ascending order. In the first cycle it presents the address with no write. In the second it writes the bitwise inverse of the returned read data to that same address.
- R5: The second read sweep expects the bitwise inverse of each address's fill value. After a fault-free run, every word of the RAM holds that inverse.
- R6: A fault-free run raises `done` with `pass`=1 and `fail_irq`=0 exactly 5N+1 clock edges after the edge that sampled `start`.
- R7: A mismatch at address a ends the run at once: `done`=1, `pass`=0 and `fail_irq`=1 appear N+a+2 edges after the start edge for a first-sweep mismatch, or 4N+a+2 edges after it for a second-sweep mismatch. No RAM writes happen after that.
- R8: `fail_irq` cannot be masked. It stays high with `done` until a new start or a reset, and a new start clears it.
- R9: `start` is ignored while a run is in progress. It restarts the engine only from idle or done.
- R10: `ram_we` is 0 whenever `done` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches a run from idle or done |
| done | output | 1 | Run finished; holds until next start |
| pass | output | 1 | Run finished with no mismatch |
| fail_irq | output | 1 | Unmaskable failure request, held with done |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | DATA_W | RAM read data, valid one cycle after the address |

## Verification
The hard overlap comes from the one-cycle read latency. The comparison for the last address of the first sweep falls in the same cycle as the first read cycle of the inversion pass. A mismatch found there has to stop the engine before the inversion write is issued. The bench provokes this with a stuck bit at address N-1 whose fill value conflicts with the forced level. It judges the result by the done latency of 2N+1 edges and by a write count of exactly N. A second overlap is a stray `start` that arrives while a run is in progress. This is judged by an unchanged 5N+1 latency and an intact write stream.

// File: rtl/ramst_pkg.sv
package ramst_pkg;

    // Engine phases; the order is the order of a full run.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_FILL  = 3'd1,
        PH_VER1  = 3'd2,
        PH_CRD   = 3'd3,
        PH_CWR   = 3'd4,
        PH_VER2  = 3'd5,
        PH_DRAIN = 3'd6,
        PH_DONE  = 3'd7
    } phase_e;

endpackage

// File: rtl/ramst_pattern.sv
// Fill value for an address: the address fitted to the data width.
module ramst_pattern #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [DATA_W-1:0] pat_o
);

    generate
        if (DATA_W > ADDR_W) begin : g_widen
            localparam int PAD_W = DATA_W - ADDR_W;
            assign pat_o = {{PAD_W{1'b0}}, addr_i};
        end else begin : g_trunc
            assign pat_o = addr_i[DATA_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/ramst_cmp.sv
// Holds the expected word for one cycle and compares it against the
// read data that arrives one clock after the address.
module ramst_cmp #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [DATA_W-1:0] exp_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              err_o
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] exp;
    } cmp_t;

    cmp_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        c_d.vld = issue_i;
        c_d.exp = exp_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign err_o = c_q.vld && (rdata_i != c_q.exp);

    // R3
    cmp_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(issue_i));

endmodule

// File: rtl/ramst_seq.sv
// Phase and address sequencer with the result flags.
module ramst_seq
    import ramst_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              err_i,
    output phase_e            phase_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o,
    output logic              pass_o,
    output logic              fail_o
);

    localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] addr;
        logic              done;
        logic              pass;
        logic              fail;
    } seq_t;

    seq_t s_d, s_q;
    logic at_last;
    logic running;

    assign at_last = (s_q.addr == LAST);
    assign running = (s_q.phase != PH_IDLE) && (s_q.phase != PH_DONE);

    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            PH_IDLE, PH_DONE: begin
                if (start_i) begin
                    s_d.phase = PH_FILL;
                    s_d.addr  = '0;
                    s_d.done  = 1'b0;
                    s_d.pass  = 1'b0;
                    s_d.fail  = 1'b0;
                end
            end
            PH_FILL: begin
                if (at_last) begin
                    s_d.phase = PH_VER1;
                    s_d.addr  = '0;
                end else begin
                    s_d.addr = s_q.addr + 1'b1;
                end
            end
            PH_VER1: begin
                if (at_last) begin
                    s_d.phase = PH_CRD;
                    s_d.addr  = '0;
                end else begin
                    s_d.addr = s_q.addr + 1'b1;
                end
            end
            PH_CRD: begin
                s_d.phase = PH_CWR;
            end
            PH_CWR: begin
                if (at_last) begin
                    s_d.phase = PH_VER2;
                    s_d.addr  = '0;
                end else begin
                    s_d.phase = PH_CRD;
                    s_d.addr  = s_q.addr + 1'b1;
                end
            end
            PH_VER2: begin
                if (at_last) begin
                    s_d.phase = PH_DRAIN;
                end else begin
                    s_d.addr = s_q.addr + 1'b1;
                end
            end
            PH_DRAIN: begin
                s_d.phase = PH_DONE;
                s_d.done  = 1'b1;
                s_d.pass  = 1'b1;
            end
            default: begin
                s_d.phase = PH_IDLE;
            end
        endcase

        // A mismatch ends any run at once.
        if (running && err_i) begin
            s_d.phase = PH_DONE;
            s_d.done  = 1'b1;
            s_d.pass  = 1'b0;
            s_d.fail  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, addr: '0, done: 1'b0, pass: 1'b0, fail: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_o = s_q.phase;
    assign addr_o  = s_q.addr;
    assign done_o  = s_q.done;
    assign pass_o  = s_q.pass;
    assign fail_o  = s_q.fail;

    // R2
    fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_FILL && $past(s_q.phase) == PH_FILL)
            |-> s_q.addr == ADDR_W'($past(s_q.addr) + 1'b1));

    // R4
    cwr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_CWR) |-> ($past(s_q.phase) == PH_CRD && $stable(s_q.addr)));

    // R8
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.fail && !start_i) |=> s_q.fail);

    // R6
    done_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.done) |-> $onehot({s_q.pass, s_q.fail}));

endmodule

// File: rtl/ram_selftest.sv
module ram_selftest
    import ramst_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              done,
    output logic              pass,
    output logic              fail_irq,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_we,
    input  logic [DATA_W-1:0] ram_rdata
);

    phase_e            phase;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] pat;
    logic [DATA_W-1:0] exp_word;
    logic              issue;
    logic              err;

    ramst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .err_i   (err),
        .phase_o (phase),
        .addr_o  (addr),
        .done_o  (done),
        .pass_o  (pass),
        .fail_o  (fail_irq)
    );

    ramst_pattern #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pat (
        .addr_i (addr),
        .pat_o  (pat)
    );

    assign issue    = (phase == PH_VER1) || (phase == PH_VER2);
    assign exp_word = (phase == PH_VER2) ? ~pat : pat;

    ramst_cmp #(.DATA_W(DATA_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue_i (issue),
        .exp_i   (exp_word),
        .rdata_i (ram_rdata),
        .err_o   (err)
    );

    assign ram_addr  = addr;
    assign ram_we    = (phase == PH_FILL) || (phase == PH_CWR);
    assign ram_wdata = (phase == PH_FILL) ? pat : ~ram_rdata;

    // R10
    quiet_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ram_we);

endmodule

// File: tb/sim_ram_selftest.sv
`timescale 1ns/1ps
module sim_ram_selftest;

    localparam int AW = 4;
    localparam int DW = 8;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          done, pass, fail_irq, ram_we;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata;
    logic [DW-1:0] ram_rdata = '0;

    int checks = 0;
    int errs   = 0;

    // RAM model with up to two read-side stuck bits
    logic [DW-1:0] mem [N];
    bit            fa_en = 0, fb_en = 0;
    int            fa_addr = 0, fa_bit = 0, fb_addr = 0, fb_bit = 0;
    bit            fa_val = 0, fb_val = 0;

    // Write monitor state
    int run_id = 0, seen_id = 0, widx = 0, wcount = 0, wfill_err = 0, wcomp_err = 0;

    ram_selftest #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .done      (done),
        .pass      (pass),
        .fail_irq  (fail_irq),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .ram_we    (ram_we),
        .ram_rdata (ram_rdata)
    );

    always #10 clk = ~clk;

    function automatic logic [DW-1:0] view(logic [DW-1:0] v, int a);
        logic [DW-1:0] r = v;
        if (fa_en && a == fa_addr) r[fa_bit] = fa_val;
        if (fb_en && a == fb_addr) r[fb_bit] = fb_val;
        return r;
    endfunction

    function automatic logic [DW-1:0] pat(int a);
        return DW'(a % (1 << DW));
    endfunction

    always @(posedge clk) begin
        if (ram_we) mem[ram_addr] <= ram_wdata;
        ram_rdata <= view(mem[ram_addr], int'(ram_addr));
    end

    always @(negedge clk) begin
        if (run_id != seen_id) begin
            seen_id = run_id;
            widx    = 0;
        end
        if (ram_we) begin
            if (widx < N) begin
                if (int'(ram_addr) != widx || ram_wdata != pat(widx)) wfill_err++;
            end else begin
                if (int'(ram_addr) != widx - N || ram_wdata != ~ram_rdata) wcomp_err++;
            end
            widx++;
            wcount++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic run(input int exp_lat, input bit exp_fail, input int exp_writes,
                       input bit poke, input string req);
        int cnt;
        int w0, f0, c0;
        w0 = wcount; f0 = wfill_err; c0 = wcomp_err;
        run_id++;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(fail_irq == 1'b0 && done == 1'b0, "R8", "verdict cleared by start",
              int'(fail_irq), 0);
        cnt = 0;
        while (!done && cnt < 10 * N) begin
            @(negedge clk);
            cnt++;
            if (poke && cnt == 20) start = 1'b1;
            if (poke && cnt == 23) start = 1'b0;
        end
        check(cnt == exp_lat, req, "done latency", cnt, exp_lat);
        check(fail_irq == exp_fail && pass == !exp_fail, req, "verdict fail_irq",
              int'(fail_irq), int'(exp_fail));
        repeat (3) @(negedge clk);
        check(wcount - w0 == exp_writes, "R7", "write count", wcount - w0, exp_writes);
        check(wfill_err == f0, "R2", "fill write stream", wfill_err - f0, 0);
        check(wcomp_err == c0, "R4", "inversion write stream", wcomp_err - c0, 0);
    endtask

    initial begin
        #(20ns * 200000);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!done && !pass && !fail_irq && !ram_we, "R1", "outputs in reset",
              int'({done, pass, fail_irq, ram_we}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !pass && !fail_irq && !ram_we, "R1", "outputs after reset",
              int'({done, pass, fail_irq, ram_we}), 0);

        // R6, R5: fault-free run
        run(5 * N + 1, 1'b0, 2 * N, 1'b0, "R6");
        for (int a = 0; a < N; a++)
            check(mem[a] == ~pat(a), "R5", "final word inverse", int'(mem[a]), int'(~pat(a)));

        // R9: stray start during a run
        run(5 * N + 1, 1'b0, 2 * N, 1'b1, "R9");

        // R3, R5, R7: single stuck bit sweep over every address, bit and level
        for (int a = 0; a < N; a++) begin
            for (int b = 0; b < DW; b++) begin
                for (int v = 0; v < 2; v++) begin
                    int p;
                    fa_en = 1; fa_addr = a; fa_bit = b; fa_val = v[0];
                    p = (b < AW) ? ((a >> b) & 1) : 0;
                    if (p != v) run(N + a + 2, 1'b1, N, 1'b0, "R3");
                    else        run(4 * N + a + 2, 1'b1, 2 * N, 1'b0, "R5");
                end
            end
        end

        // R8, R10: verdict held and RAM quiet while done
        repeat (10) @(negedge clk);
        check(done && fail_irq && !pass, "R8", "fail held", int'(fail_irq), 1);
        check(!ram_we, "R10", "no write while done", int'(ram_we), 0);

        // R7: two faults, earlier in time wins even at higher address
        fa_en = 1; fa_addr = 12; fa_bit = 2; fa_val = 0;
        fb_en = 1; fb_addr = 5;  fb_bit = 1; fb_val = 0;
        run(N + 12 + 2, 1'b1, N, 1'b0, "R7");
        fa_en = 0; fb_en = 0;

        // R8: clean restart clears the verdict
        run(5 * N + 1, 1'b0, 2 * N, 1'b0, "R8");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule